// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a wide synchronous up-counter built as a chain of identical 4-bit slices. Each slice has a parallel load, two active-high count enables and a terminal-count flag. The flag is high when the slice holds all ones and its trickle enable is high. Inside the wrapper, each slice's terminal count drives the trickle enable of the next slice. As a result, a slice advances only on the edge where every slice below it wraps. The parallel enable of every slice comes straight from the external input, so it gates counting without adding to the ripple path.

On every rising clock edge each slice selects one of four modes, in fixed precedence:

- clear: reset is active.
- load: the active-low load is asserted.
- step: both enables are high.
- keep: all other cases.

The mode is re-evaluated every edge from the control inputs, so any mode can follow any other. A parameter chooses how reset acts. In the asynchronous variant it clears the count at once, without a clock edge. In the synchronous variant it takes effect as the clear mode at the next edge. A second parameter sets the number of slices.

Top module: `cnt_cascade`

## Requirements
- R1: When rst_n, load_n, cnt_en_p and cnt_en_t are all high at a rising edge, count becomes the previous count plus one, modulo 2^(4·SLICES).
- R2: Counting from the all-ones value gives zero at the next edge.
- R3: With rst_n high and load_n low, the next edge loads load_val into count, whatever the enables are.
- R4: With rst_n and load_n high and either cnt_en_p or cnt_en_t low, count keeps its value across the edge.
- R5: With ASYNC_RST=1, a low rst_n forces count to zero at once, without waiting for a clock edge.
- R6: With ASYNC_RST=0, a low rst_n leaves count unchanged until the next rising edge, and that edge clears count to zero.
- R7: carry_out is high exactly when count is all ones and cnt_en_t is high. Neither cnt_en_p nor load_n affects it.
- R8: While counting, bits above the lowest 4-bit slice change only on an edge where the lowest slice held 4'hF.
- R9: When rst_n and load_n are both low, reset wins and count becomes zero, not load_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous per ASYNC_RST |
| load_n | input | 1 | Active-low parallel load enable |
| load_val | input | 4·SLICES | Value to load, slice 0 in the low nibble |
| cnt_en_p | input | 1 | Parallel count enable, fed to every slice |
| cnt_en_t | input | 1 | Trickle count enable into slice 0 |
| count | output | 4·SLICES | Concatenated counter state |
| carry_out | output | 1 | Terminal count of the last slice |

## Verification
Reset and parallel load can arrive in the same cycle, and so can load and counting at the all-ones value. The bench provokes both on purpose, and random stimulus produces them often. The expected outcome is judged by a bench model that applies the clear > load > step > keep order. Both reset variants run side by side on the same stimulus. A mid-cycle reset is sampled before the edge, where only the asynchronous copy may already read zero, and again after it, where both must.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_STEP  = 2'd2,
        MODE_KEEP  = 2'd3
    } mode_e;
endpackage

// File: rtl/cnt_mode_sel.sv
// Picks the operating mode of one slice for the coming edge.
module cnt_mode_sel
    import cnt_pkg::*;
#(
    parameter bit SYNC_CLEAR = 1'b0
) (
    input  logic  clear_n,
    input  logic  load_n,
    input  logic  en_p,
    input  logic  en_t,
    output mode_e mode
);
    always_comb begin
        if (SYNC_CLEAR && !clear_n) begin
            mode = MODE_CLEAR;
        end else if (!load_n) begin
            mode = MODE_LOAD;
        end else if (en_p && en_t) begin
            mode = MODE_STEP;
        end else begin
            mode = MODE_KEEP;
        end
    end
endmodule

// File: rtl/cnt_next.sv
// Next-state function of one slice for a given mode.
module cnt_next
    import cnt_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  mode_e        mode,
    input  logic [W-1:0] q,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_nxt = '0;
            MODE_LOAD:  q_nxt = d;
            MODE_STEP:  q_nxt = q + ONE;
            MODE_KEEP:  q_nxt = q;
            default:    q_nxt = q;
        endcase
    end
endmodule

// File: rtl/cnt_slice.sv
// One presettable slice with a selectable reset style.
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int W         = SLICE_W,
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] d,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         tc
);
    mode_e        mode;
    logic [W-1:0] q_nxt;

    cnt_mode_sel #(.SYNC_CLEAR(!ASYNC_RST)) u_sel (
        .clear_n (rst_n),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .mode    (mode)
    );

    cnt_next #(.W(W)) u_nxt (
        .mode  (mode),
        .q     (q),
        .d     (d),
        .q_nxt (q_nxt)
    );

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= q_nxt;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= q_nxt;
            end
        end
    endgenerate

    assign tc = (&q) & en_t;
endmodule

// File: rtl/cnt_cascade.sv
// Chains SLICES counter slices through the terminal-count ripple.
module cnt_cascade
    import cnt_pkg::*;
#(
    parameter int SLICES    = 4,
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_n,
    input  logic [SLICES*SLICE_W-1:0] load_val,
    input  logic                      cnt_en_p,
    input  logic                      cnt_en_t,
    output logic [SLICES*SLICE_W-1:0] count,
    output logic                      carry_out
);
    localparam int CW = SLICES * SLICE_W;

    logic [SLICES:0] ripple;

    assign ripple[0] = cnt_en_t;

    generate
        for (genvar i = 0; i < SLICES; i++) begin : g_slice
            cnt_slice #(.W(SLICE_W), .ASYNC_RST(ASYNC_RST)) u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_n (load_n),
                .d      (load_val[i*SLICE_W +: SLICE_W]),
                .en_p   (cnt_en_p),
                .en_t   (ripple[i]),
                .q      (count[i*SLICE_W +: SLICE_W]),
                .tc     (ripple[i+1])
            );
        end
    endgenerate

    assign carry_out = ripple[SLICES];
endmodule

// File: rtl/cnt_cascade_chk.sv
module cnt_cascade_chk
    import cnt_pkg::*;
#(
    parameter int SLICES    = 4,
    parameter bit ASYNC_RST = 1'b1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      load_n,
    input logic [SLICES*SLICE_W-1:0] load_val,
    input logic                      cnt_en_p,
    input logic                      cnt_en_t,
    input logic [SLICES*SLICE_W-1:0] count,
    input logic                      carry_out
);
    localparam int CW = SLICES * SLICE_W;

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_p && cnt_en_t) |=> count == CW'($past(count) + CW'(1)));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_p && cnt_en_t && (&count)) |=> count == '0);

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n) |=> count == $past(load_val));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

    assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out == ((&count) && cnt_en_t));

    generate
        if (ASYNC_RST) begin : g_async_chk
            assert_async_clear_R5: assert property (@(posedge clk)
                !rst_n |-> count == '0);
        end else begin : g_sync_chk
            assert_sync_clear_R6: assert property (@(posedge clk)
                !rst_n |=> count == '0);
            assert_clear_over_load_R9: assert property (@(posedge clk)
                (!rst_n && !load_n) |=> count == '0);
        end
        if (SLICES > 1) begin : g_ripple_chk
            assert_ripple_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (load_n && cnt_en_p && cnt_en_t && (count[SLICE_W-1:0] != {SLICE_W{1'b1}}))
                |=> $stable(count[CW-1:SLICE_W]));
        end
    endgenerate
endmodule

bind cnt_cascade cnt_cascade_chk #(.SLICES(SLICES), .ASYNC_RST(ASYNC_RST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .load_val  (load_val),
    .cnt_en_p  (cnt_en_p),
    .cnt_en_t  (cnt_en_t),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/cnt_cascade_test.sv
module cnt_cascade_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;
    localparam int CW = NS * 4;
    localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n, load_n, en_p, en_t;
    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt_a, cnt_s;
    logic          cy_a, cy_s;
    logic [CW-1:0] model;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    cnt_cascade #(.SLICES(NS), .ASYNC_RST(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .count(cnt_a), .carry_out(cy_a));

    cnt_cascade #(.SLICES(NS), .ASYNC_RST(1'b0)) uut_s (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
        .cnt_en_p(en_p), .cnt_en_t(en_t), .count(cnt_s), .carry_out(cy_s));

    function automatic logic [CW-1:0] f_next(logic [CW-1:0] cur, logic r, logic l,
                                             logic [CW-1:0] v, logic p, logic t);
        if (!r)          return '0;
        else if (!l)     return v;
        else if (p && t) return cur + CW'(1);
        else             return cur;
    endfunction

    task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(logic r, logic l, logic [CW-1:0] v, logic p, logic t);
        logic [CW-1:0] exp;
        string tag;
        @(negedge clk);
        rst_n = r; load_n = l; load_val = v; en_p = p; en_t = t;
        #1;
        if (!r) begin
            check("R5 async clear before edge", cnt_a, '0);
            check("R6 sync holds before edge", cnt_s, model);
        end else begin
            check("R7 carry async", CW'(cy_a), CW'((model == ALL1) && t));
            check("R7 carry sync", CW'(cy_s), CW'((model == ALL1) && t));
        end
        exp = f_next(model, r, l, v, p, t);
        if (!r && !l)                      tag = "R9";
        else if (!r)                       tag = "R6";
        else if (!l)                       tag = "R3";
        else if (p && t && model == ALL1)  tag = "R2";
        else if (p && t && model[3:0] == 4'hF) tag = "R8";
        else if (p && t)                   tag = "R1";
        else                               tag = "R4";
        @(posedge clk);
        #1;
        check({tag, " async"}, cnt_a, exp);
        check({tag, " sync"}, cnt_s, exp);
        model = exp;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0; load_n = 1'b1; load_val = '0; en_p = 1'b0; en_t = 1'b0;
        model = '0;
        @(posedge clk); @(posedge clk); #1;
        check("R5 reset state", cnt_a, '0);
        check("R6 reset state", cnt_s, '0);

        // load just below full range, count through the wrap
        cycle(1, 0, ALL1 - CW'(2), 0, 0);
        cycle(1, 1, '0, 1, 1);
        cycle(1, 1, '0, 1, 1);
        cycle(1, 1, '0, 1, 1);
        // carry independent of parallel enable and load (R7), gated by trickle
        cycle(1, 0, ALL1, 0, 1);
        cycle(1, 1, '0, 0, 1);
        cycle(1, 0, 12'h123, 0, 1);
        cycle(1, 0, ALL1, 1, 0);
        cycle(1, 1, '0, 1, 0);
        // ripple across slice boundaries (R8)
        cycle(1, 0, 12'h0FE, 1, 1);
        cycle(1, 1, '0, 1, 1);
        cycle(1, 1, '0, 1, 1);
        // reset beats load (R9), mid-cycle reset timing (R5/R6)
        cycle(1, 0, 12'hA5C, 0, 0);
        cycle(0, 0, 12'h777, 1, 1);
        cycle(1, 0, 12'h3C3, 1, 1);
        cycle(0, 1, '0, 1, 1);

        for (int i = 0; i < 600; i++) begin
            cycle(($urandom % 30) != 0, ($urandom % 6) != 0, CW'($urandom),
                  ($urandom % 5) != 0, ($urandom % 5) != 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule